// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block tracks interrupt requests and in-service interrupts for one processor over an 8-bit vector space. Sources post a vector through a set port. The resolver finds the highest requested vector and offers it as pending only when it outranks the current processor priority. The consumer takes the offered vector with an accept strobe. That moves the vector from the request set to the in-service set and pushes it on a nesting stack. An end-of-interrupt strobe retires the most recently accepted vector.

The processor priority is derived from two things: a software-written task priority and the vector on top of the nesting stack. Priorities are compared by class, which is the upper nibble of a value. Vectors below 32 are reserved and are never offered. Misuse raises sticky error flags: an end-of-interrupt with nothing in service, or an accept when the nesting stack is full.

Top module: `prio_resolver`

## Requirements
- R1: After reset the task priority, the processor priority and both error flags read 0, and no vector is pending.
- R2: A set request for a vector of 32 or above marks it requested. A set request for vectors 0 to 31 has no effect, so such a vector never appears as pending.
- R3: The pending output offers the highest requested vector in 32..255. It is valid only when that vector's class (bits 7:4) is strictly greater than the class of the processor priority. Otherwise pend_valid_o is 0.
- R4: With T as the task priority and S as the top in-service vector (0 when nothing is in service), the processor priority is T when T[7:4] >= S[7:4], and {S[7:4],4'h0} otherwise.
- R5: A task-priority write stores the 8-bit value. It reads back on tpr_o and updates the processor priority after one clock edge.
- R6: An accept while a vector is pending clears that vector's request, marks it in service and pushes it on the stack. An accept with nothing pending is ignored. Stacked classes strictly increase from bottom to top.
- R7: An end-of-interrupt clears the highest in-service vector and pops the stack, which restores the previous processor priority. The in-service set always matches the stack contents.
- R8: An end-of-interrupt with nothing in service changes no state and sets eoi_err_o, which stays set until reset.
- R9: An accept when the stack holds STK_DEPTH entries is suppressed: the request stays set and nothing is pushed. It sets ovf_err_o, which stays set until reset.
- R10: When accept and end-of-interrupt arrive in the same cycle, only the end-of-interrupt is performed.
- R11: A set request in the same cycle as the accept of that same vector leaves the vector requested as well as in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_set_i | input | 1 | Post a request for req_vec_i |
| req_vec_i | input | 8 | Vector to post |
| accept_i | input | 1 | Take the currently pending vector into service |
| eoi_i | input | 1 | End of interrupt for the top in-service vector |
| tpr_we_i | input | 1 | Task-priority write enable |
| tpr_wdata_i | input | 8 | Task-priority write data |
| tpr_o | output | 8 | Task priority |
| pend_valid_o | output | 1 | A vector may be delivered |
| pend_vec_o | output | 8 | Vector offered for delivery |
| ppr_o | output | 8 | Processor priority |
| eoi_err_o | output | 1 | Sticky end-of-interrupt underflow flag |
| ovf_err_o | output | 1 | Sticky nesting-stack overflow flag |

## Verification
Every input takes effect at the rising edge that samples it. The outputs are combinational functions of registered state, so tpr_o, ppr_o, the pending pair and both error flags all show the new result one edge after the stimulus, with no further lag. The bench drives each stimulus on the falling edge, lets exactly one rising edge pass, and compares every output on the following falling edge against a bit-level model of the request set, the in-service set and the stack. That model is written from the requirements. The sweeps cover every vector, every task-priority value and the same-cycle collisions. A second instance with a two-entry stack reaches the overflow case.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;
  localparam int RSVD    = 32;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_of(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/prio_hi_find.sv
module prio_hi_find import prio_pkg::*; #(
  parameter int N  = NUM_VEC,
  parameter int LO = RSVD
) (
  input  logic [N-1:0] bits_i,
  output logic         found_o,
  output vec_t         idx_o
);
  // ascending scan, last hit is the highest set bit
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = LO; i < N; i++) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_isr_stack.sv
module prio_isr_stack import prio_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  vec_t             push_vec_i,
  output vec_t             top_vec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  vec_t             stk_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] wr_idx;

  assign top_idx   = IDX_W'(cnt_q - 1'b1);
  assign wr_idx    = IDX_W'(cnt_q);
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign top_vec_o = empty_o ? '0 : stk_q[top_idx];
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && !full_o) begin
      stk_q[wr_idx] <= push_vec_i;
      cnt_q         <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_push_class_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty_o) |-> (cls_of(push_vec_i) > cls_of(top_vec_o)));
  p_no_push_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o && $stable(cnt_q));
  p_no_push_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver import prio_pkg::*; #(
  parameter int STK_DEPTH = 16,
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_set_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             accept_i,
  input  logic             eoi_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  output logic [VEC_W-1:0] tpr_o,
  output logic             pend_valid_o,
  output logic [VEC_W-1:0] pend_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_err_o,
  output logic             ovf_err_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, irr_d, isr_d;
  vec_t               tpr_q, irr_hi, isr_hi, top_vec;
  logic               irr_found, isr_found;
  logic               stk_full, stk_empty;
  logic [CNT_W-1:0]   stk_cnt;
  logic               do_acc, push, pop;
  logic               eoi_err_q, ovf_err_q;

  prio_hi_find #(.N(NUM_VEC), .LO(RSVD)) u_irr_find (
    .bits_i(irr_q), .found_o(irr_found), .idx_o(irr_hi));
  prio_hi_find #(.N(NUM_VEC), .LO(RSVD)) u_isr_find (
    .bits_i(isr_q), .found_o(isr_found), .idx_o(isr_hi));

  prio_isr_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .push_vec_i(irr_hi),
    .top_vec_o(top_vec), .cnt_o(stk_cnt),
    .full_o(stk_full), .empty_o(stk_empty));

  // processor priority and delivery gate
  always_comb begin
    if (cls_of(tpr_q) >= cls_of(top_vec)) ppr_o = tpr_q;
    else                                  ppr_o = {cls_of(top_vec), {(VEC_W-CLS_W){1'b0}}};
  end
  assign pend_valid_o = irr_found && (cls_of(irr_hi) > cls_of(ppr_o));
  assign pend_vec_o   = irr_hi;

  // eoi wins over a same-cycle accept
  assign do_acc = accept_i && pend_valid_o && !eoi_i;
  assign push   = do_acc && !stk_full;
  assign pop    = eoi_i && !stk_empty;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    if (push) begin
      irr_d[irr_hi] = 1'b0;
      isr_d[irr_hi] = 1'b1;
    end
    if (pop) isr_d[isr_hi] = 1'b0;
    if (req_set_i && (req_vec_i >= VEC_W'(RSVD))) irr_d[req_vec_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tpr_q     <= '0;
      eoi_err_q <= 1'b0;
      ovf_err_q <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (tpr_we_i)               tpr_q     <= tpr_wdata_i;
      if (eoi_i && stk_empty)     eoi_err_q <= 1'b1;
      if (do_acc && stk_full)     ovf_err_q <= 1'b1;
    end
  end

  assign tpr_o     = tpr_q;
  assign eoi_err_o = eoi_err_q;
  assign ovf_err_o = ovf_err_q;

  p_isr_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stk_empty |-> (isr_found && (isr_hi == top_vec)));
  p_isr_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q) == int'(stk_cnt));
  p_tpr_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_i |=> (tpr_o == $past(tpr_wdata_i)));
  p_eoi_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_err_o |=> eoi_err_o);
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);
  p_no_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> (pend_vec_o >= VEC_W'(RSVD)));
endmodule

// File: tb/prio_resolver_tb.sv
`timescale 1ns/100ps
module prio_resolver_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       set_en = 0, acc = 0, eoi = 0, tw = 0;
  logic [7:0] set_vec = 0, twd = 0;
  logic [7:0] tpr, pvec, ppr;
  logic       pv, eerr, oerr;

  prio_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(set_en), .req_vec_i(set_vec),
    .accept_i(acc), .eoi_i(eoi), .tpr_we_i(tw), .tpr_wdata_i(twd),
    .tpr_o(tpr), .pend_valid_o(pv), .pend_vec_o(pvec), .ppr_o(ppr),
    .eoi_err_o(eerr), .ovf_err_o(oerr));

  // small-stack instance for the overflow case
  logic       s_set = 0, s_acc = 0;
  logic [7:0] s_vec = 0;
  logic [7:0] s_tpr, s_pvec, s_ppr;
  logic       s_pv, s_eerr, s_oerr;

  prio_resolver #(.STK_DEPTH(2)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(s_set), .req_vec_i(s_vec),
    .accept_i(s_acc), .eoi_i(1'b0), .tpr_we_i(1'b0), .tpr_wdata_i(8'h00),
    .tpr_o(s_tpr), .pend_valid_o(s_pv), .pend_vec_o(s_pvec), .ppr_o(s_ppr),
    .eoi_err_o(s_eerr), .ovf_err_o(s_oerr));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [255:0] m_irr = '0, m_isr = '0;
  logic [7:0]   m_stk [16];
  int           m_cnt = 0;
  logic [7:0]   m_tpr = 0;
  bit           m_eerr = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_ppr();
    int top = (m_cnt > 0) ? int'(m_stk[m_cnt-1]) : 0;
    if ((int'(m_tpr) >> 4) >= (top >> 4)) return int'(m_tpr);
    return top & 8'hF0;
  endfunction

  function automatic int m_hi_req();
    for (int i = 255; i >= 32; i--) if (m_irr[i]) return i;
    return -1;
  endfunction

  function automatic bit m_pv();
    int h = m_hi_req();
    return (h >= 0) && ((h >> 4) > (m_ppr() >> 4));
  endfunction

  task automatic check_all(input string req);
    chk(req, "tpr_o", int'(tpr), int'(m_tpr));
    chk(req, "ppr_o", int'(ppr), m_ppr());
    chk(req, "pend_valid_o", int'(pv), int'(m_pv()));
    if (m_pv()) chk(req, "pend_vec_o", int'(pvec), m_hi_req());
    chk(req, "eoi_err_o", int'(eerr), int'(m_eerr));
    chk(req, "ovf_err_o", int'(oerr), 0);
  endtask

  // drive at falling edge, one rising edge, compare at next falling edge
  task automatic op(input bit s, input int sv, input bit a, input bit e,
                    input bit w, input int wv, input string req);
    bit pv0 = m_pv();
    int h0  = m_hi_req();
    set_en = s; set_vec = 8'(sv); acc = a; eoi = e; tw = w; twd = 8'(wv);
    if (e) begin
      if (m_cnt == 0) m_eerr = 1;
      else begin m_isr[m_stk[m_cnt-1]] = 1'b0; m_cnt--; end
    end else if (a && pv0) begin
      m_irr[h0] = 1'b0; m_isr[h0] = 1'b1; m_stk[m_cnt] = 8'(h0); m_cnt++;
    end
    if (s && sv >= 32) m_irr[sv] = 1'b1;
    if (w) m_tpr = 8'(wv);
    @(posedge clk);
    @(negedge clk);
    set_en = 0; acc = 0; eoi = 0; tw = 0;
    check_all(req);
  endtask

  task automatic small_step(input bit s, input int sv, input bit a);
    s_set = s; s_vec = 8'(sv); s_acc = a;
    @(posedge clk);
    @(negedge clk);
    s_set = 0; s_acc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");

    // R8 underflow from empty
    op(0, 0, 0, 1, 0, 0, "R8");
    op(0, 0, 0, 1, 0, 0, "R8");

    // R2 R3 R6 R7 every vector alone: post, take, retire
    for (int v = 0; v < 256; v++) begin
      op(1, v, 0, 0, 0, 0, (v < 32) ? "R2" : "R3");
      if (v >= 32) begin
        op(0, 0, 1, 0, 0, 0, "R6");
        op(0, 0, 0, 1, 0, 0, "R7");
      end
    end
    // R6 accept with nothing pending
    op(0, 0, 1, 0, 0, 0, "R6");

    // R4 R5 task-priority sweep with 0x85 in service and 0xC3 requested
    op(1, 8'h85, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 0, 0, 0, "R6");
    op(1, 8'hC3, 0, 0, 0, 0, "R3");
    for (int t = 0; t < 256; t++) op(0, 0, 0, 0, 1, t, "R4");
    op(0, 0, 0, 0, 1, 0, "R5");
    op(0, 0, 1, 0, 0, 0, "R6");
    op(0, 0, 0, 1, 0, 0, "R7");
    op(0, 0, 0, 1, 0, 0, "R7");

    // R3 R6 R7 nesting with several requests outstanding
    op(1, 8'h35, 0, 0, 0, 0, "R3");
    op(1, 8'h9A, 0, 0, 0, 0, "R3");
    op(1, 8'h72, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 0, 0, 0, "R6");
    op(1, 8'hF1, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 0, 0, 0, "R6");
    op(1, 8'h9F, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 0, 0, 0, "R6");
    for (int k = 0; k < 5; k++) begin
      op(0, 0, 0, 1, 0, 0, "R7");
      op(0, 0, 1, 0, 0, 0, "R6");
    end
    for (int k = 0; k < 6; k++) op(0, 0, 0, 1, 0, 0, "R7");

    // R10 accept and eoi together
    op(1, 8'h40, 0, 0, 0, 0, "R10");
    op(0, 0, 1, 0, 0, 0, "R10");
    op(1, 8'h70, 0, 0, 0, 0, "R10");
    op(0, 0, 1, 1, 0, 0, "R10");
    chk("R10", "pend_vec_o after collision", int'(pvec), 8'h70);

    // R11 same vector posted while being accepted
    op(1, 8'h70, 1, 0, 0, 0, "R11");
    chk("R11", "pend_valid_o while in service", int'(pv), 0);
    op(0, 0, 0, 1, 0, 0, "R11");
    chk("R11", "pend_valid_o after retire", int'(pv), 1);
    chk("R11", "pend_vec_o after retire", int'(pvec), 8'h70);

    // R9 overflow on a two-deep stack
    small_step(1, 8'h40, 0);
    small_step(0, 0, 1);
    small_step(1, 8'h50, 0);
    small_step(0, 0, 1);
    small_step(1, 8'h60, 0);
    chk("R9", "small pend_valid_o before", int'(s_pv), 1);
    chk("R9", "small ovf_err_o before", int'(s_oerr), 0);
    small_step(0, 0, 1);
    chk("R9", "small ovf_err_o", int'(s_oerr), 1);
    chk("R9", "small ppr_o", int'(s_ppr), 8'h50);
    chk("R9", "small pend_valid_o", int'(s_pv), 1);
    chk("R9", "small pend_vec_o", int'(s_pvec), 8'h60);
    small_step(0, 0, 0);
    chk("R9", "small ovf_err_o sticky", int'(s_oerr), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule